// File: doc/BRIEF.md
# Integer Ratio Clock Divider

This block turns a fast reference clock into a slower square wave whose period is a fixed whole number of reference cycles, `DIV_N`. The ratio is a single elaboration-time parameter. Changing it changes the output rate without touching the logic. Typical uses are slow strobes, scan clocks and blink rates taken from a system clock.

The block has two variants, chosen by the `HALF_DUTY` parameter.

- **Balanced variant.** A counter runs from zero up to `DIV_N/2 - 1`. The match at that value does two things: it restarts the counter and it enables a self-inverting flop. The flop's output is the divided clock, with equal high and low times.
- **Lean variant.** The counter wraps after `DIV_N` states, and its top bit is used as the output. The period is still `DIV_N`, but the high time is generally shorter than the low time.

A synchronous reset puts the counter and the output in a known phase. The first output phase after reset is low.

Top module: `intdiv_clkgen`

## Requirements
- R1: While `srst` is high at a rising edge of `clk_in`, after that edge the internal count is 0 and `clk_out` is 0.
- R2: With `HALF_DUTY`=1 and an even `DIV_N` ≥ 2, `clk_out` repeats with a period of exactly `DIV_N` cycles of `clk_in`.
- R3: With `HALF_DUTY`=1, every high phase and every low phase of `clk_out` lasts `DIV_N/2` cycles. The first phase after reset is low.
- R4: With `HALF_DUTY`=1, `clk_out` inverts after each edge at which the count matches `DIV_N/2 - 1`, and holds after every other edge.
- R5: After an edge at which the count is at its terminal value, the count is 0.
- R6: When the count is below its terminal value and reset is low, each edge raises the count by exactly one.
- R7: With `HALF_DUTY`=0, `clk_out` repeats with a period of exactly `DIV_N` cycles.
- R8: With `HALF_DUTY`=0, `clk_out` is the top bit of a counter of width ceil(log2(`DIV_N`)). Let P be the largest power of two below `DIV_N`. Each period is then low for P cycles, starting from reset, followed by high for `DIV_N` − P cycles.
- R9: The count never exceeds its terminal value: `DIV_N/2 - 1` in the balanced variant, `DIV_N - 1` in the lean variant.
- R10: Reset asserted in the middle of a period restarts the waveform from the start of a low phase of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast reference clock |
| srst | input | 1 | Synchronous reset, active high |
| clk_out | output | 1 | Divided clock |

## Verification
Every result appears one register stage after the edge that causes it. A terminal match clears the count, and in the balanced variant flips the output, both visible after the same edge. The bench samples on the falling edge, half a cycle after each update, and counts how many consecutive samples hold each output level. The sample taken while reset is held counts as the first cycle of the opening low phase, so each measured run length equals the phase length in `clk_in` cycles. Several ratios of both variants run side by side, with their expected phase lengths derived in the bench by arithmetic.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

  // Counter width for a given ratio and variant.
  function automatic int cnt_width(input int n, input bit half_duty);
    int span;
    span = half_duty ? (n / 2) : n;
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

  // Terminal count value at which the counter restarts.
  function automatic int term_value(input int n, input bit half_duty);
    return half_duty ? (n / 2 - 1) : (n - 1);
  endfunction

endpackage

// File: rtl/intdiv_count.sv
module intdiv_count #(
  parameter int W   = 4,
  parameter int LIM = 9
) (
  input  logic         clk,
  input  logic         srst,
  output logic [W-1:0] cnt,
  output logic         at_term
);
  localparam logic [W-1:0] TERM = W'(LIM);

  assign at_term = (cnt == TERM);

  always_ff @(posedge clk) begin
    if (srst)         cnt <= '0;
    else if (at_term) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/intdiv_tff.sv
module intdiv_tff (
  input  logic clk,
  input  logic srst,
  input  logic en,
  output logic q
);
  always_ff @(posedge clk) begin
    if (srst)    q <= 1'b0;
    else if (en) q <= ~q;
  end
endmodule

// File: rtl/intdiv_clkgen.sv
module intdiv_clkgen #(
  parameter int DIV_N     = 10,
  parameter bit HALF_DUTY = 1'b1
) (
  input  logic clk_in,
  input  logic srst,
  output logic clk_out
);
  import intdiv_pkg::*;

  localparam int CW   = cnt_width(DIV_N, HALF_DUTY);
  localparam int CLIM = term_value(DIV_N, HALF_DUTY);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  intdiv_count #(.W(CW), .LIM(CLIM)) u_cnt (
    .clk     (clk_in),
    .srst    (srst),
    .cnt     (cnt_q),
    .at_term (wrap)
  );

  generate
    if (HALF_DUTY) begin : g_balanced
      if ((DIV_N % 2) != 0 || DIV_N < 2) begin : g_bad_ratio
        $error("balanced variant needs an even ratio of at least 2");
      end
      intdiv_tff u_tff (
        .clk  (clk_in),
        .srst (srst),
        .en   (wrap),
        .q    (clk_out)
      );
    end else begin : g_lean
      if (DIV_N < 2) begin : g_bad_ratio
        $error("ratio must be at least 2");
      end
      assign clk_out = cnt_q[CW-1];
    end
  endgenerate
endmodule

// File: rtl/intdiv_clkgen_chk.sv
module intdiv_clkgen_chk #(
  parameter int W         = 4,
  parameter int LIM       = 4,
  parameter bit HALF_DUTY = 1'b1
) (
  input logic         clk,
  input logic         srst,
  input logic [W-1:0] cnt,
  input logic         wrap,
  input logic         clk_out
);
  a_r1_reset_clears: assert property (@(posedge clk)
    srst |=> (cnt == '0) && (clk_out == 1'b0));

  a_r5_restart: assert property (@(posedge clk) disable iff (srst)
    wrap |=> (cnt == '0));

  a_r6_step: assert property (@(posedge clk) disable iff (srst)
    !wrap |=> (cnt == W'($past(cnt) + 1'b1)));

  a_r9_bound: assert property (@(posedge clk) disable iff (srst)
    (int'(cnt) <= LIM));

  generate
    if (HALF_DUTY) begin : g_bal
      a_r4_flip_on_match: assert property (@(posedge clk) disable iff (srst)
        wrap |=> (clk_out != $past(clk_out)));
      a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (srst)
        !wrap |=> $stable(clk_out));
    end
  endgenerate
endmodule

bind intdiv_clkgen intdiv_clkgen_chk #(
  .W(CW), .LIM(CLIM), .HALF_DUTY(HALF_DUTY)
) u_chk (
  .clk     (clk_in),
  .srst    (srst),
  .cnt     (cnt_q),
  .wrap    (wrap),
  .clk_out (clk_out)
);

// File: tb/sim_intdiv_clkgen.sv
module sim_intdiv_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 10;
  localparam int CFG_N[NCFG]   = '{2, 4, 6, 10, 16, 2, 3, 5, 8, 12};
  localparam bit CFG_HALF[NCFG] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0};

  logic clk_in = 1'b0;
  logic srst   = 1'b1;
  int   n_cmp  = 0;
  int   n_bad  = 0;
  int   cyc    = 0;

  always #(CLK_PERIOD / 2) clk_in = ~clk_in;

  task automatic chk(input string req, input int cfg, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cfg%0d: actual %0d expected %0d", req, cfg, act, exp);
    end
  endtask

  // Largest power of two strictly below n, found by doubling.
  function automatic int pow_below(input int n);
    int p;
    p = 1;
    while (p * 2 < n) p = p * 2;
    return p;
  endfunction

  function automatic int exp_low(input int n, input bit half);
    return half ? n / 2 : pow_below(n);
  endfunction

  function automatic int exp_high(input int n, input bit half);
    return half ? n / 2 : n - pow_below(n);
  endfunction

  for (genvar g = 0; g < NCFG; g++) begin : g_dut
    logic q;
    int   run;
    int   last_high;
    logic prev;
    bit   first_low;

    intdiv_clkgen #(.DIV_N(CFG_N[g]), .HALF_DUTY(CFG_HALF[g])) u0 (
      .clk_in  (clk_in),
      .srst    (srst),
      .clk_out (q)
    );

    always @(negedge clk_in) begin
      if (srst) begin
        if (cyc > 2) chk("R1 output low in reset", g, int'(q), 0);
        run       = 1;
        prev      = 1'b0;
        last_high = 0;
        first_low = 1'b1;
      end else if (q === prev) begin
        run++;
      end else begin
        if (prev == 1'b0) begin
          // low phase just ended
          if (CFG_HALF[g]) chk(first_low ? "R3/R10 first low" : "R3 low", g, run, exp_low(CFG_N[g], 1'b1));
          else             chk(first_low ? "R8/R10 first low" : "R8 low", g, run, exp_low(CFG_N[g], 1'b0));
          if (last_high != 0) begin
            if (CFG_HALF[g]) chk("R2 period", g, last_high + run, CFG_N[g]);
            else             chk("R7 period", g, last_high + run, CFG_N[g]);
          end
          first_low = 1'b0;
        end else begin
          if (CFG_HALF[g]) chk("R3 high", g, run, exp_high(CFG_N[g], 1'b1));
          else             chk("R8 high", g, run, exp_high(CFG_N[g], 1'b0));
          last_high = run;
        end
        prev = q;
        run  = 1;
      end
    end
  end

  // Watchdog
  always @(posedge clk_in) begin
    cyc++;
    if (cyc > 5000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 5000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_in);
    #(CLK_PERIOD / 4) srst = 1'b0;
    repeat (157) @(negedge clk_in);
    // R10: reset in mid-period
    #(CLK_PERIOD / 4) srst = 1'b1;
    repeat (3) @(negedge clk_in);
    #(CLK_PERIOD / 4) srst = 1'b0;
    repeat (200) @(negedge clk_in);
    #(CLK_PERIOD / 4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule